// File: doc/BRIEF.md
# Sample Output Format Converter

This block sits at the output of a sampling datapath. It takes 16-bit samples in offset-binary form and re-expresses each one in a selected number format: offset binary, twos complement or Gray code. It can then complement every bit of the result. A local disable control gates the result. The stage is pipelined, with a valid flag that travels with the data and a fixed latency of one clock.

The format select, invert bit and disable bit are sampled on the same clock edge as the sample they apply to. Software or a neighbouring block can therefore change them between samples and have the change take effect on exactly the next presented sample. Pad drivers are not modelled. A disabled output appears as a low output-enable flag together with all-zero data. The pipeline keeps moving while the output is disabled.

Top module: `sample_format_converter`

## Requirements
- R1: `validOut` equals `validIn` from the previous clock edge, a fixed latency of one cycle.
- R2: With `fmtSel` = 2'b00, invert off and output enabled, a valid sample appears on `dataOut` unchanged one cycle later.
- R3: With `fmtSel` = 2'b01, the result is the sample with bit 15 complemented and bits 14..0 unchanged (twos complement).
- R4: With `fmtSel` = 2'b10, the result is the Gray code `s ^ (s >> 1)`, where `s` is the sample.
- R5: `fmtSel` = 2'b11 gives the same result as 2'b00.
- R6: With `invertEn` = 1, the result is the bitwise complement of the format-converted word, in every format.
- R7: When `outDisable` = 1 at an edge, after that edge `outEnable` = 0 and `dataOut` = 0, whatever the value of `validIn`. `validOut` still follows R1.
- R8: When `validIn` = 0 and `outDisable` = 0 at an edge, `dataOut` keeps its previous value and `outEnable` = 1.
- R9: During reset, `dataOut` = 0, `validOut` = 0 and `outEnable` = 1. This is the default state: offset binary, invert off, outputs enabled.
- R10: Format, invert and disable settings apply per sample. A setting presented together with a sample governs that sample only, so back-to-back samples may use different settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 16 | Offset-binary input sample |
| validIn | input | 1 | Input sample valid |
| fmtSel | input | 2 | Output format: 00/11 offset binary, 01 twos complement, 10 Gray |
| invertEn | input | 1 | Complement the converted word |
| outDisable | input | 1 | Force output disabled and zero |
| dataOut | output | 16 | Converted sample |
| validOut | output | 1 | Output sample valid |
| outEnable | output | 1 | High when outputs are enabled |

## Verification
The assertions check the following on every cycle:
- the one-cycle alignment of `validOut`;
- the zero data that goes with a low `outEnable`;
- the hold of `dataOut` when no sample arrives;
- the passthrough and complement cases of the offset-binary formats, both codes included;
- the MSB-only difference of twos complement.

Only the bench scenarios can show the rest:
- the full Gray result at the extreme codes;
- the complement applied on top of the Gray and twos-complement forms;
- the reset values;
- the recovery from a disable;
- back-to-back samples that each carry a different setting.

// File: rtl/sofc_pkg.sv
package sofc_pkg;

  typedef enum logic [1:0] {
    FMT_OFFSET     = 2'b00,
    FMT_TWOS       = 2'b01,
    FMT_GRAY       = 2'b10,
    FMT_OFFSET_ALT = 2'b11
  } fmtCode_e;

  typedef struct packed {
    logic flipMsb;   // twos complement select
    logic useGray;   // Gray code select
    logic invert;    // complement after conversion
    logic gateOff;   // force disabled / zero data
    logic load;      // capture a new word
  } dpStrobes_t;

endpackage

// File: rtl/sofc_ctrl.sv
module sofc_ctrl
  import sofc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] fmtSel,
  input  logic       invertEn,
  input  logic       outDisable,
  input  logic       validIn,
  output dpStrobes_t strobes
);

  fmtCode_e fmtCode;

  always_comb begin
    fmtCode = fmtCode_e'(fmtSel);
    strobes = '0;
    unique case (fmtCode)
      FMT_TWOS:       strobes.flipMsb = 1'b1;
      FMT_GRAY:       strobes.useGray = 1'b1;
      FMT_OFFSET,
      FMT_OFFSET_ALT: ;
      default:        ;
    endcase
    strobes.invert  = invertEn;
    strobes.gateOff = outDisable;
    strobes.load    = validIn & ~outDisable;
  end

  // R3/R4: at most one conversion path is chosen at a time
  a_r4_one_format: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.flipMsb, strobes.useGray}));

  // R7: a disabled cycle never loads a new word
  a_r7_no_load_when_off: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gateOff |-> !strobes.load);

endmodule

// File: rtl/sofc_datapath.sv
module sofc_datapath
  import sofc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                validIn,
  input  dpStrobes_t          strobes,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                validOut,
  output logic                outEnable
);

  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] grayWord;
  logic [SAMPLE_W-1:0] twosWord;
  logic [SAMPLE_W-1:0] convWord;
  logic [SAMPLE_W-1:0] finalWord;

  // Gray: each bit is the xor of itself and its upper neighbour
  genvar gi;
  generate
    for (gi = 0; gi < MSB; gi++) begin : g_gray
      assign grayWord[gi] = sampleIn[gi] ^ sampleIn[gi+1];
    end
  endgenerate
  assign grayWord[MSB] = sampleIn[MSB];

  assign twosWord = {~sampleIn[MSB], sampleIn[MSB-1:0]};

  always_comb begin
    if (strobes.useGray)      convWord = grayWord;
    else if (strobes.flipMsb) convWord = twosWord;
    else                      convWord = sampleIn;
    finalWord = strobes.invert ? ~convWord : convWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= '0;
      validOut  <= 1'b0;
      outEnable <= 1'b1;
    end else begin
      validOut  <= validIn;
      outEnable <= ~strobes.gateOff;
      if (strobes.gateOff)   dataOut <= '0;
      else if (strobes.load) dataOut <= finalWord;
    end
  end

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1: valid is delayed by one clock
  a_r1_valid_align: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> validOut == $past(validIn));

  // R7: disabled output carries zero data
  a_r7_zero_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> dataOut == '0);

  // R8: no sample and enabled -> data held
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(!validIn && !strobes.gateOff)) |-> $stable(dataOut));

endmodule

// File: rtl/sample_format_converter.sv
module sample_format_converter
  import sofc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                validIn,
  input  logic [1:0]          fmtSel,
  input  logic                invertEn,
  input  logic                outDisable,
  output logic [SAMPLE_W-1:0] dataOut,
  output logic                validOut,
  output logic                outEnable
);

  localparam int MSB = SAMPLE_W - 1;

  dpStrobes_t strobes;

  sofc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fmtSel     (fmtSel),
    .invertEn   (invertEn),
    .outDisable (outDisable),
    .validIn    (validIn),
    .strobes    (strobes)
  );

  sofc_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleIn  (sampleIn),
    .validIn   (validIn),
    .strobes   (strobes),
    .dataOut   (dataOut),
    .validOut  (validOut),
    .outEnable (outEnable)
  );

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R2: code 00, no invert -> passthrough
  a_r2_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(validIn && !outDisable && fmtSel == 2'b00 && !invertEn))
      |-> dataOut == $past(sampleIn));

  // R5: code 11 behaves as 00
  a_r5_offset_alt: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(validIn && !outDisable && fmtSel == 2'b11 && !invertEn))
      |-> dataOut == $past(sampleIn));

  // R6: invert on offset binary gives the complement
  a_r6_invert_offset: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(validIn && !outDisable && fmtSel[0] == fmtSel[1] && invertEn))
      |-> dataOut == ~$past(sampleIn));

  // R3: twos complement differs only in the MSB
  a_r3_twos_msb: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(validIn && !outDisable && fmtSel == 2'b01 && !invertEn))
      |-> (dataOut[MSB] != $past(sampleIn[MSB]))
          && (dataOut[MSB-1:0] == $past(sampleIn[MSB-1:0])));

endmodule

// File: tb/sample_format_converter_test.sv
`timescale 1ns/1ps
module sample_format_converter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        validIn = 1'b0;
  logic [1:0]  fmtSel = 2'b00;
  logic        invertEn = 1'b0;
  logic        outDisable = 1'b0;
  logic [15:0] dataOut;
  logic        validOut;
  logic        outEnable;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sample_format_converter uut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .validIn(validIn),
    .fmtSel(fmtSel), .invertEn(invertEn), .outDisable(outDisable),
    .dataOut(dataOut), .validOut(validOut), .outEnable(outEnable)
  );

  typedef struct packed {
    logic [15:0] data;
    logic        valid;
    logic        en;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  logic [15:0] modelData = '0;

  function automatic logic [15:0] refConv(logic [15:0] s, logic [1:0] f, logic inv);
    logic [15:0] r;
    case (f)
      2'b01:   r = s ^ 16'h8000;
      2'b10:   r = s ^ (s >> 1);
      default: r = s;
    endcase
    return inv ? ~r : r;
  endfunction

  task automatic drive(input logic [15:0] s, input logic v, input logic [1:0] f,
                       input logic inv, input logic dis, input string tag);
    expItem_t e;
    @(negedge clk);
    sampleIn = s; validIn = v; fmtSel = f; invertEn = inv; outDisable = dis;
    if (dis)    modelData = '0;
    else if (v) modelData = refConv(s, f, inv);
    e.data = modelData; e.valid = v; e.en = ~dis;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (dataOut !== e.data || validOut !== e.valid || outEnable !== e.en) begin
          errors++;
          $display("FAIL %s: got data=%h valid=%b en=%b exp data=%h valid=%b en=%b",
                   t, dataOut, validOut, outEnable, e.data, e.valid, e.en);
        end
      end
    end
  end

  // watchdog
  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (dataOut !== 16'h0 || validOut !== 1'b0 || outEnable !== 1'b1) begin
      errors++;
      $display("FAIL R9: got data=%h valid=%b en=%b exp data=0000 valid=0 en=1",
               dataOut, validOut, outEnable);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2 offset binary passthrough
    drive(16'h1234, 1, 2'b00, 0, 0, "R2");
    drive(16'h8000, 1, 2'b00, 0, 0, "R2");
    drive(16'hFFFF, 1, 2'b00, 0, 0, "R2");
    // R3 twos complement at the code extremes
    drive(16'h0000, 1, 2'b01, 0, 0, "R3");
    drive(16'h8000, 1, 2'b01, 0, 0, "R3");
    drive(16'h7FFF, 1, 2'b01, 0, 0, "R3");
    drive(16'hFFFF, 1, 2'b01, 0, 0, "R3");
    // R4 Gray
    drive(16'hFFFF, 1, 2'b10, 0, 0, "R4");
    drive(16'h8000, 1, 2'b10, 0, 0, "R4");
    drive(16'hA5C3, 1, 2'b10, 0, 0, "R4");
    drive(16'h0001, 1, 2'b10, 0, 0, "R4");
    // R5 code 11 equals code 00
    drive(16'h4321, 1, 2'b11, 0, 0, "R5");
    drive(16'hC0DE, 1, 2'b11, 0, 0, "R5");
    // R6 invert in each format
    drive(16'h1234, 1, 2'b00, 1, 0, "R6");
    drive(16'h1234, 1, 2'b01, 1, 0, "R6");
    drive(16'h1234, 1, 2'b10, 1, 0, "R6");
    drive(16'h0F0F, 1, 2'b11, 1, 0, "R6");
    // R8 hold while idle, R1 valid low
    drive(16'hDEAD, 0, 2'b00, 0, 0, "R8");
    drive(16'hBEEF, 0, 2'b10, 1, 0, "R8");
    drive(16'h5555, 0, 2'b01, 0, 0, "R1");
    // R7 disable with and without a valid sample
    drive(16'h7777, 1, 2'b00, 0, 1, "R7");
    drive(16'h3333, 0, 2'b10, 1, 1, "R7");
    drive(16'hFFFF, 1, 2'b01, 0, 1, "R7");
    // recovery after disable; idle keeps zero
    drive(16'h2222, 0, 2'b00, 0, 0, "R8");
    drive(16'h2468, 1, 2'b00, 0, 0, "R7");
    // R10 per-sample switching back to back
    drive(16'h9ABC, 1, 2'b10, 0, 0, "R10");
    drive(16'h9ABC, 1, 2'b01, 1, 0, "R10");
    drive(16'h9ABC, 1, 2'b00, 0, 1, "R10");
    drive(16'h9ABC, 1, 2'b11, 1, 0, "R10");
    drive(16'h9ABC, 1, 2'b01, 0, 0, "R10");
    // R1 alternating valid
    drive(16'h0101, 1, 2'b00, 0, 0, "R1");
    drive(16'h0202, 0, 2'b00, 0, 0, "R1");
    drive(16'h0303, 1, 2'b00, 0, 0, "R1");
    @(negedge clk);
    validIn = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule